// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase signals of an incremental rotary or linear encoder into a position count. The phase inputs are assumed to be synchronised to the block clock already. The block compares each sample with the one before it. A change of exactly one phase is a count edge, and its direction follows from which phase leads. Every edge of either phase counts, which is x4 decoding. A change of both phases in the same sample cannot be decoded, so it is flagged as an error.

Edges pass through a power-of-two divider before they move the position counter. The counter runs inside a window set by a start value and an end value, and it wraps at either end. Software reaches the block through a small word-addressed register port with a one-cycle write strobe and combinational read data. A lock bit guards the configuration registers. Only a dedicated release bit can clear it.

Top module: `qdec_timer`

## Requirements
- R1: While counting is on, each sample in which exactly one phase changes is one edge. Take the sample as the two-bit value {A,B}. Edges along the order 00→01→11→10→00 step up, and edges along the reverse order step down. The position counter follows in the same clock edge when the divider is 1.
- R2: The divider code is the 3-bit field ctrl[2:0]. It sets the divider to 2^code, from 1 up to 128. Up edges add one to a net edge tally and down edges subtract one. The counter steps up when the tally reaches +2^code and down when it reaches −2^code. The tally then returns to zero.
- R3: An up step from the end value loads the start value. A down step from the start value loads the end value. Any other step moves the counter by exactly one.
- R4: Any write to the count register loads the start value into the counter and clears the edge tally, whatever data is written.
- R5: Writing 1 to status bit 0 sets the lock. While the lock is set, writes to ctrl, start, end and qctrl are ignored, and so is mode bit 0. Counting goes on unchanged.
- R6: Writing 1 to mode bit 1 while the lock is set clears the lock. While the lock is clear, that bit has no effect. Mode bit 1 always reads as 0.
- R7: Writes to the start and end registers are accepted only while mode bit 0 (enable) is 1.
- R8: After reset: counter 0, start 0x0000, end 0xFFFF, divider code 0, enable 0, qctrl 0, lock 0, error 0.
- R9: If both phases change in one sample while counting is on, the counter does not step and status bit 1 (error) is set. The error bit stays set until 1 is written to status bit 1.
- R10: Edges are counted only while qctrl bit 0 is 1. While it is 0, phase changes move neither the counter nor the tally.
- R11: The word addresses are: 0 ctrl, 1 count (reads the live counter), 2 start, 3 end, 4 mode, 5 status, 6 qctrl. Address 7 reads 0. Read data is combinational from the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ph_a | input | 1 | Encoder phase A, already synchronised |
| ph_b | input | 1 | Encoder phase B, already synchronised |
| wr_en | input | 1 | One-cycle write strobe |
| addr | input | 3 | Word address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data |

## Verification
The phases are driven through forward and backward sequences and through reversals in the middle of a run. This separates the direction decode from the edge detection. Runs that stop one edge short of the divider threshold and then reach it show whether the divider tallies net edges or raw edges. A run of 127 edges under code 7 checks the widest tally. Jumps of both phases at once, phase activity with counting disabled, and register writes under the lock show that these inputs leave the count and the configuration untouched.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  localparam int RA_CTRL  = 0;
  localparam int RA_COUNT = 1;
  localparam int RA_START = 2;
  localparam int RA_END   = 3;
  localparam int RA_MODE  = 4;
  localparam int RA_STAT  = 5;
  localparam int RA_QCTL  = 6;
endpackage

// File: rtl/qdec_edge.sv
module qdec_edge (
  input  logic clk,
  input  logic rst,
  input  logic ph_a,
  input  logic ph_b,
  output logic move,
  output logic dir_up,
  output logic bad
);
  logic [1:0] prev_q;
  logic [1:0] diff;

  // prev tracks the inputs even in reset, so no false edge follows reset
  always_ff @(posedge clk) begin
    if (rst) prev_q <= {ph_a, ph_b};
    else     prev_q <= {ph_a, ph_b};
  end

  always_comb begin
    diff   = prev_q ^ {ph_a, ph_b};
    move   = (diff == 2'b01) || (diff == 2'b10);
    bad    = (diff == 2'b11);
    dir_up = prev_q[1] ^ ph_b;
  end
endmodule

// File: rtl/qdec_prescale.sv
module qdec_prescale #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            move,
  input  logic            dir_up,
  input  logic            clr,
  input  logic [PS_W-1:0] ps,
  output logic            step_up,
  output logic            step_dn
);
  localparam int MAX_SH = (1 << PS_W) - 1;
  localparam int ACC_W  = MAX_SH + 2;
  localparam logic signed [ACC_W-1:0] ONE = ACC_W'(1);

  logic signed [ACC_W-1:0] acc_q, acc_nx, sum, thr;

  always_comb begin
    thr     = ONE <<< ps;
    sum     = dir_up ? acc_q + ONE : acc_q - ONE;
    step_up = 1'b0;
    step_dn = 1'b0;
    acc_nx  = acc_q;
    if (clr) begin
      acc_nx = '0;
    end else if (move) begin
      if (sum == thr) begin
        step_up = 1'b1;
        acc_nx  = '0;
      end else if (sum == -thr) begin
        step_dn = 1'b1;
        acc_nx  = '0;
      end else begin
        acc_nx = sum;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_nx;
  end
endmodule

// File: rtl/qdec_counter.sv
module qdec_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step_up,
  input  logic             step_dn,
  input  logic [CNT_W-1:0] start_v,
  input  logic [CNT_W-1:0] end_v,
  output logic [CNT_W-1:0] count_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (load) begin
      count_q <= start_v;
    end else if (step_up) begin
      count_q <= (count_q == end_v) ? start_v : count_q + 1'b1;
    end else if (step_dn) begin
      count_q <= (count_q == start_v) ? end_v : count_q - 1'b1;
    end
  end
endmodule

// File: rtl/qdec_regs.sv
module qdec_regs
  import qdec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              bad_evt,
  input  logic [CNT_W-1:0]  count_q,
  output logic [PS_W-1:0]   ps_q,
  output logic              en_q,
  output logic              qen_q,
  output logic [CNT_W-1:0]  start_q,
  output logic [CNT_W-1:0]  end_q,
  output logic              lock_q,
  output logic              err_q,
  output logic              count_ld,
  output logic              ps_ld,
  output logic [DATA_W-1:0] rd_data
);
  logic hit_ctrl, hit_cnt, hit_start, hit_end, hit_mode, hit_stat, hit_qctl;
  logic unused_hi;

  assign unused_hi = ^wr_data[DATA_W-1:CNT_W];

  always_comb begin
    hit_ctrl  = wr_en && (addr == ADDR_W'(RA_CTRL));
    hit_cnt   = wr_en && (addr == ADDR_W'(RA_COUNT));
    hit_start = wr_en && (addr == ADDR_W'(RA_START));
    hit_end   = wr_en && (addr == ADDR_W'(RA_END));
    hit_mode  = wr_en && (addr == ADDR_W'(RA_MODE));
    hit_stat  = wr_en && (addr == ADDR_W'(RA_STAT));
    hit_qctl  = wr_en && (addr == ADDR_W'(RA_QCTL));
    count_ld  = hit_cnt;
    ps_ld     = hit_ctrl && !lock_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ps_q    <= '0;
      en_q    <= 1'b0;
      qen_q   <= 1'b0;
      start_q <= '0;
      end_q   <= '1;
      lock_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (ps_ld) ps_q <= wr_data[PS_W-1:0];
      if (hit_start && !lock_q && en_q) start_q <= wr_data[CNT_W-1:0];
      if (hit_end && !lock_q && en_q) end_q <= wr_data[CNT_W-1:0];
      if (hit_qctl && !lock_q) qen_q <= wr_data[0];
      if (hit_mode) begin
        if (lock_q) begin
          if (wr_data[1]) lock_q <= 1'b0;
        end else begin
          en_q <= wr_data[0];
        end
      end
      if (hit_stat && wr_data[0] && !lock_q) lock_q <= 1'b1;
      if (bad_evt) err_q <= 1'b1;
      else if (hit_stat && wr_data[1]) err_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      ADDR_W'(RA_CTRL):  rd_data[PS_W-1:0]  = ps_q;
      ADDR_W'(RA_COUNT): rd_data[CNT_W-1:0] = count_q;
      ADDR_W'(RA_START): rd_data[CNT_W-1:0] = start_q;
      ADDR_W'(RA_END):   rd_data[CNT_W-1:0] = end_q;
      ADDR_W'(RA_MODE):  rd_data[0]         = en_q;
      ADDR_W'(RA_STAT):  rd_data[1:0]       = {err_q, lock_q};
      ADDR_W'(RA_QCTL):  rd_data[0]         = qen_q;
      default:           rd_data            = '0;
    endcase
  end
endmodule

// File: rtl/qdec_timer.sv
module qdec_timer #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ph_a,
  input  logic              ph_b,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  logic             move, dir_up, bad;
  logic             step_up, step_dn;
  logic [PS_W-1:0]  ps_q;
  logic             en_q, qen_q, lock_q, err_q;
  logic [CNT_W-1:0] start_q, end_q, count_q;
  logic             count_ld, ps_ld;
  logic             move_g, bad_evt, pre_clr;

  assign move_g  = move & qen_q;
  assign bad_evt = bad & qen_q;
  assign pre_clr = count_ld | ps_ld;

  qdec_edge u_edge (
    .clk(clk), .rst(rst), .ph_a(ph_a), .ph_b(ph_b),
    .move(move), .dir_up(dir_up), .bad(bad)
  );

  qdec_prescale #(.PS_W(PS_W)) u_pre (
    .clk(clk), .rst(rst), .move(move_g), .dir_up(dir_up), .clr(pre_clr),
    .ps(ps_q), .step_up(step_up), .step_dn(step_dn)
  );

  qdec_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(count_ld), .step_up(step_up), .step_dn(step_dn),
    .start_v(start_q), .end_v(end_q), .count_q(count_q)
  );

  qdec_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PS_W(PS_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .bad_evt(bad_evt), .count_q(count_q), .ps_q(ps_q), .en_q(en_q), .qen_q(qen_q),
    .start_q(start_q), .end_q(end_q), .lock_q(lock_q), .err_q(err_q),
    .count_ld(count_ld), .ps_ld(ps_ld), .rd_data(rd_data)
  );
endmodule

// File: rtl/qdec_timer_chk.sv
module qdec_timer_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [CNT_W-1:0]  count_q,
  input logic [CNT_W-1:0]  start_q,
  input logic [CNT_W-1:0]  end_q,
  input logic              lock_q,
  input logic              en_q,
  input logic              qen_q,
  input logic              err_q,
  input logic              bad
);
  logic cnt_wr;
  assign cnt_wr = wr_en && (addr == ADDR_W'(1));

  // R4: a count write loads the start value
  a_r4_count_reload: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (count_q == $past(start_q)));

  // R3: without a reload the counter moves by one or wraps into the window
  a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
    !cnt_wr |=> (count_q == $past(count_q)) || (count_q == $past(count_q) + 1'b1) ||
                (count_q == $past(count_q) - 1'b1) || (count_q == $past(start_q)) ||
                (count_q == $past(end_q)));

  // R10: counting off holds the counter
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!qen_q && !cnt_wr) |=> $stable(count_q));

  // R9: a double change sets the error flag and does not step
  a_r9_bad_no_step: assert property (@(posedge clk) disable iff (rst)
    (bad && qen_q && !cnt_wr) |=> ($stable(count_q) && err_q));

  // R5: locked start/end cannot be written
  a_r5_lock_start: assert property (@(posedge clk) disable iff (rst)
    (lock_q && wr_en && (addr == ADDR_W'(2))) |=> $stable(start_q));

  // R7: start/end writes need the enable bit
  a_r7_end_gate: assert property (@(posedge clk) disable iff (rst)
    (!en_q && wr_en && (addr == ADDR_W'(3))) |=> $stable(end_q));

  // R6: a release write while locked clears the lock
  a_r6_release: assert property (@(posedge clk) disable iff (rst)
    (lock_q && wr_en && (addr == ADDR_W'(4)) && wr_data[1]) |=> !lock_q);
endmodule

bind qdec_timer qdec_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .count_q(count_q), .start_q(start_q), .end_q(end_q), .lock_q(lock_q),
  .en_q(en_q), .qen_q(qen_q), .err_q(err_q), .bad(bad)
);

// File: tb/qdec_timer_tb_top.sv
`timescale 1ns/1ps
module qdec_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pa = 1'b0, pb = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd1;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;

  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  qdec_timer dut_i (
    .clk(clk), .rst(rst), .ph_a(pa), .ph_b(pb),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
  );

  // reference model state
  int m_cnt, m_start, m_end, m_ps, m_acc;
  bit m_en, m_qen, m_lock, m_err;
  logic [1:0] m_prev = 2'b00;

  always @(posedge clk) begin
    logic [1:0] cur, d;
    bit su, sd, seterr;
    cur = {pa, pb};
    if (rst) begin
      m_cnt = 0; m_start = 0; m_end = 'hFFFF; m_ps = 0; m_acc = 0;
      m_en = 0; m_qen = 0; m_lock = 0; m_err = 0;
    end else begin
      su = 0; sd = 0; seterr = 0;
      d = cur ^ m_prev;
      if (m_qen) begin
        if (d == 2'b11) seterr = 1;
        else if (d != 2'b00) begin
          m_acc += ((m_prev[1] ^ cur[0]) ? 1 : -1);
          if (m_acc == (1 << m_ps)) begin su = 1; m_acc = 0; end
          else if (m_acc == -(1 << m_ps)) begin sd = 1; m_acc = 0; end
        end
      end
      if (wr_en && addr == 3'd1) begin
        m_cnt = m_start; m_acc = 0;
      end else if (wr_en && addr == 3'd0 && !m_lock) begin
        m_acc = 0;
      end else if (su) begin
        m_cnt = (m_cnt == m_end) ? m_start : ((m_cnt + 1) & 'hFFFF);
      end else if (sd) begin
        m_cnt = (m_cnt == m_start) ? m_end : ((m_cnt - 1) & 'hFFFF);
      end
      if (wr_en) begin
        case (addr)
          3'd0: if (!m_lock) m_ps = int'(wr_data[2:0]);
          3'd2: if (!m_lock && m_en) m_start = int'(wr_data[15:0]);
          3'd3: if (!m_lock && m_en) m_end = int'(wr_data[15:0]);
          3'd4: if (m_lock) begin if (wr_data[1]) m_lock = 0; end else m_en = wr_data[0];
          3'd5: begin
            if (wr_data[0] && !m_lock) m_lock = 1;
            if (wr_data[1]) m_err = 0;
          end
          3'd6: if (!m_lock) m_qen = wr_data[0];
          default: ;
        endcase
      end
      if (seterr) m_err = 1;
    end
    m_prev = cur;
  end

  // per-cycle comparison of the live count against the model
  always @(posedge clk) begin
    #5;
    if (!rst && !done && addr == 3'd1) begin
      total++;
      if (rd_data[15:0] !== m_cnt[15:0]) begin
        bad++;
        $display("FAIL R1 model count: actual=%h expected=%h", rd_data[15:0], m_cnt[15:0]);
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    addr = a;
    #1 chk(req, rd_data, exp);
    addr = 3'd1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 3'd1; wr_data = '0;
  endtask

  task automatic edges(input int n, input bit up);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      case ({pa, pb})
        2'b00: {pa, pb} = up ? 2'b01 : 2'b10;
        2'b01: {pa, pb} = up ? 2'b11 : 2'b00;
        2'b11: {pa, pb} = up ? 2'b10 : 2'b01;
        default: {pa, pb} = up ? 2'b00 : 2'b11;
      endcase
    end
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8, R11 reset state and map
    rd(3'd0, 0, "R8 ctrl");
    rd(3'd1, 0, "R8 count");
    rd(3'd2, 0, "R8 start");
    rd(3'd3, 32'hFFFF, "R8 end");
    rd(3'd4, 0, "R8 mode");
    rd(3'd5, 0, "R8 status");
    rd(3'd6, 0, "R8 qctrl");
    rd(3'd7, 0, "R11 unused address");
    // R10 counting off
    edges(4, 1);
    rd(3'd1, 0, "R10 idle");
    wr(3'd6, 1);
    // R1 direction
    edges(8, 1);
    rd(3'd1, 8, "R1 up");
    edges(3, 0);
    rd(3'd1, 5, "R1 down");
    // R4 reload, R3 wrap at full range
    wr(3'd1, 32'h1234);
    rd(3'd1, 0, "R4 reload ignores data");
    edges(1, 0);
    rd(3'd1, 32'hFFFF, "R3 down wrap");
    edges(1, 1);
    rd(3'd1, 0, "R3 up wrap");
    // R7 enable gate
    wr(3'd2, 32'h10);
    rd(3'd2, 0, "R7 start blocked");
    wr(3'd4, 1);
    wr(3'd2, 32'h10);
    wr(3'd3, 32'h13);
    rd(3'd2, 32'h10, "R7 start accepted");
    rd(3'd3, 32'h13, "R7 end accepted");
    wr(3'd1, 32'hABCD);
    rd(3'd1, 32'h10, "R4 reload to start");
    edges(3, 1);
    rd(3'd1, 32'h13, "R3 reach end");
    edges(1, 1);
    rd(3'd1, 32'h10, "R3 up wrap window");
    edges(1, 0);
    rd(3'd1, 32'h13, "R3 down wrap window");
    // R2 divider
    wr(3'd0, 2);
    wr(3'd1, 0);
    edges(8, 1);
    rd(3'd1, 32'h12, "R2 div4 up");
    edges(3, 0);
    rd(3'd1, 32'h12, "R2 div4 short");
    edges(1, 0);
    rd(3'd1, 32'h11, "R2 div4 down");
    wr(3'd0, 7);
    wr(3'd1, 0);
    edges(127, 1);
    rd(3'd1, 32'h10, "R2 div128 short");
    edges(1, 1);
    rd(3'd1, 32'h11, "R2 div128 step");
    wr(3'd0, 0);
    // R9 illegal
    @(negedge clk);
    {pa, pb} = ~{pa, pb};
    @(negedge clk);
    rd(3'd1, 32'h11, "R9 no step");
    rd(3'd5, 2, "R9 error set");
    edges(2, 1);
    rd(3'd5, 2, "R9 error sticky");
    wr(3'd5, 2);
    rd(3'd5, 0, "R9 error cleared");
    // count now 0x13 after 2 up steps
    // R5 lock
    wr(3'd5, 1);
    rd(3'd5, 1, "R5 lock set");
    wr(3'd2, 5);
    wr(3'd3, 7);
    wr(3'd0, 3);
    wr(3'd6, 0);
    wr(3'd4, 0);
    rd(3'd2, 32'h10, "R5 start held");
    rd(3'd3, 32'h13, "R5 end held");
    rd(3'd0, 0, "R5 ctrl held");
    rd(3'd6, 1, "R5 qctrl held");
    rd(3'd4, 1, "R5 mode held");
    edges(1, 1);
    rd(3'd1, 32'h10, "R5 counting while locked");
    // R6 release
    wr(3'd4, 2);
    rd(3'd5, 0, "R6 released");
    rd(3'd4, 1, "R6 enable kept, release bit reads 0");
    wr(3'd4, 2);
    rd(3'd5, 0, "R6 no effect unlocked");
    rd(3'd4, 0, "R6 enable follows bit0");
    // R10 off again
    wr(3'd6, 0);
    edges(2, 1);
    rd(3'd1, 32'h10, "R10 halted");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule